// File: doc/BRIEF.md
# Two-Level Cascaded DMA Request Arbiter

This block decides which of eight DMA request lines may own the bus. The lines are split into two groups of four. The lower group covers channels 0 to 3. It raises one combined hold request, and that request feeds the first input of the upper group. The upper group covers channels 5 to 7, plus the cascade input that stands in for channel 4. Only the upper group talks to the processor: it raises the processor hold request and waits for the hold acknowledge before it grants. A grant from the upper group on its cascade input serves as the lower group's hold acknowledge.

Priority is fixed, with channel 0 the highest and channel 7 the lowest. Because the cascade input is the upper group's highest input, every lower-group channel outranks channels 5 to 7. Once a channel holds the acknowledge it keeps it until a session-done pulse arrives, even if a more urgent request appears. After that pulse, every acknowledge stays low for at least one cycle before the next winner is chosen.

A mask input removes channels from arbitration. A width flag tells the transfer logic whether the granted channel belongs to the 8-bit group (0 to 3) or the 16-bit group (5 to 7). A requesting device is expected to hold its line until it is acknowledged.

Top module: `dma_cascade_arb`

## Requirements
- R1: Among unmasked pending requests, the lowest channel number wins, and channels 0 to 3 always beat channels 5 to 7.
- R2: An acknowledge, once given, stays unchanged until done_i is sampled high, whatever other requests arrive.
- R3: In the cycle after done_i is sampled, all acknowledges are low, and they stay low for at least one cycle before the next grant.
- R4: hold_req_o rises within two cycles of an unmasked request on channels 5 to 7, and within three cycles of one on channels 0 to 3. It is low when no unmasked request has been pending for three cycles and no session is open.
- R5: No acknowledge is issued while hlda_i is low. hold_req_o still rises in that case.
- R6: A channel whose mask_i bit is 1 is never acknowledged and does not raise hold_req_o. Bit 4 of req_i and of mask_i has no effect, and ack_o[4] is never high.
- R7: At most one bit of ack_o is high at any time.
- R8: wide_o is 1 while ack_o has a bit high among 5 to 7, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Request lines; bit 4 is ignored |
| mask_i | input | 8 | 1 excludes a channel; bit 4 is ignored |
| hlda_i | input | 1 | Processor hold acknowledge |
| done_i | input | 1 | One-cycle pulse that ends the current session |
| hold_req_o | output | 1 | Processor hold request |
| ack_o | output | 8 | One-hot acknowledge; bit 4 is always 0 |
| wide_o | output | 1 | 1 when the granted channel is a 16-bit channel |

## Verification
The bench builds the arbiter with its default of four channels per group. This places the cascade input on channel 4 and gives the 8-bit and 16-bit groups their full sizes. With these values, a lower-group grant crosses both stages in series, so a bench can compare the lower group's longer latency with that of the upper group. It also means a pending request from each group can be pitted against the other, and the unused cascade bit can be driven to show that it is ignored.

// File: rtl/dca_pkg.sv
package dca_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_GAP  = 2'd2
    } arb_state_e;
endpackage

// File: rtl/dca_prio_pick.sv
module dca_prio_pick #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] pend_i,
    output logic [NCH-1:0] pick_o
);
    always_comb begin
        pick_o = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                pick_o    = '0;
                pick_o[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dca_group.sv
module dca_group
    import dca_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req_i,
    input  logic [NCH-1:0] mask_i,
    input  logic           hlda_i,
    input  logic           done_i,
    output logic           hrq_o,
    output logic [NCH-1:0] ack_o
);
    typedef struct packed {
        arb_state_e     st;
        logic           hrq;
        logic [NCH-1:0] ack;
    } grp_reg_t;

    grp_reg_t       r_d, r_q;
    logic [NCH-1:0] pend_w;
    logic [NCH-1:0] pick_w;

    assign pend_w = req_i & ~mask_i;

    dca_prio_pick #(.NCH(NCH)) u_pick (
        .pend_i (pend_w),
        .pick_o (pick_w)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                r_d.hrq = |pend_w;
                if (r_q.hrq && hlda_i && (|pend_w)) begin
                    r_d.ack = pick_w;
                    r_d.st  = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (done_i) begin
                    r_d.ack = '0;
                    r_d.hrq = 1'b0;
                    r_d.st  = ST_GAP;
                end
            end
            ST_GAP: begin
                r_d.hrq = |pend_w;
                r_d.st  = ST_IDLE;
            end
            default: begin
                r_d.st  = ST_IDLE;
                r_d.hrq = 1'b0;
                r_d.ack = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.hrq <= 1'b0;
            r_q.ack <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign hrq_o = r_q.hrq;
    assign ack_o = r_q.ack;

    p_onehot_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o));
    p_hold_session_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ack_o) && !done_i) |=> $stable(ack_o));
    p_gap_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ack_o) && done_i) |=> (ack_o == '0));
    p_grant_needs_hlda_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|ack_o) |-> $past(hlda_i));
    p_hold_while_granted_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_o) |-> hrq_o);
endmodule

// File: rtl/dma_cascade_arb.sv
module dma_cascade_arb #(
    parameter int GRP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2*GRP-1:0] req_i,
    input  logic [2*GRP-1:0] mask_i,
    input  logic             hlda_i,
    input  logic             done_i,
    output logic             hold_req_o,
    output logic [2*GRP-1:0] ack_o,
    output logic             wide_o
);
    localparam int NTOT = 2 * GRP;
    localparam int CASC = GRP;

    logic           s_hrq;
    logic [GRP-1:0] s_ack;
    logic [GRP-1:0] m_req, m_mask, m_ack;
    logic           m_hrq;
    logic           unused_casc_bits;

    assign unused_casc_bits = req_i[CASC] ^ mask_i[CASC];

    dca_group #(.NCH(GRP)) u_slave (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_i[GRP-1:0]),
        .mask_i (mask_i[GRP-1:0]),
        .hlda_i (m_ack[0]),
        .done_i (done_i),
        .hrq_o  (s_hrq),
        .ack_o  (s_ack)
    );

    assign m_req  = {req_i[NTOT-1:CASC+1], s_hrq};
    assign m_mask = {mask_i[NTOT-1:CASC+1], 1'b0};

    dca_group #(.NCH(GRP)) u_master (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (m_req),
        .mask_i (m_mask),
        .hlda_i (hlda_i),
        .done_i (done_i),
        .hrq_o  (m_hrq),
        .ack_o  (m_ack)
    );

    assign hold_req_o = m_hrq;
    assign ack_o      = {m_ack[GRP-1:1], 1'b0, s_ack};
    assign wide_o     = |m_ack[GRP-1:1];

    p_total_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o));
    p_slave_inside_cascade_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|s_ack) |-> m_ack[0]);
    p_wide_only_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wide_o |-> (s_ack == '0));
endmodule

// File: tb/dma_cascade_arb_test.sv
module dma_cascade_arb_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_i = '0;
    logic [7:0] mask_i = '0;
    logic       hlda_i = 1'b1;
    logic       done_i = 1'b0;
    logic       hold_req_o;
    logic [7:0] ack_o;
    logic       wide_o;

    int errors = 0;
    int checks = 0;
    bit multi_seen = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dma_cascade_arb uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_i(mask_i),
        .hlda_i(hlda_i), .done_i(done_i), .hold_req_o(hold_req_o),
        .ack_o(ack_o), .wide_o(wide_o)
    );

    always @(negedge clk) if (rst_n && $countones(ack_o) > 1) multi_seen = 1'b1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_grant(input logic [7:0] exp, input string tag);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (ack_o != 0) break;
        end
        chk(ack_o == exp, tag, ack_o, exp);
    endtask

    task automatic end_session(input int ch, input string tag);
        @(negedge clk);
        done_i = 1'b1;
        req_i[ch] = 1'b0;
        @(negedge clk);
        done_i = 1'b0;
        chk(ack_o == 0, tag, ack_o, 0);
        @(negedge clk);
        chk(ack_o == 0, tag, ack_o, 0);
    endtask

    task automatic t_reset;
        chk(ack_o == 0, "R7 reset ack", ack_o, 0);
        chk(hold_req_o == 0, "R4 reset hold", hold_req_o, 0);
        chk(wide_o == 0, "R8 reset wide", wide_o, 0);
    endtask

    task automatic t_slave_order;
        req_i = 8'b0000_1100;
        wait_grant(8'b0000_0100, "R1 ch2 before ch3");
        chk(wide_o == 0, "R8 narrow ch2", wide_o, 0);
        end_session(2, "R3 gap after ch2");
        wait_grant(8'b0000_1000, "R1 ch3 next");
        end_session(3, "R3 gap after ch3");
    endtask

    task automatic t_cross_group;
        req_i = 8'b0100_0010;
        wait_grant(8'b0000_0010, "R1 ch1 beats ch6");
        end_session(1, "R3 gap after ch1");
        wait_grant(8'b0100_0000, "R1 ch6 next");
        chk(wide_o == 1, "R8 wide ch6", wide_o, 1);
        end_session(6, "R3 gap after ch6");
        cycles(3);
        chk(hold_req_o == 0, "R4 hold drops when idle", hold_req_o, 0);
    endtask

    task automatic t_nonpreempt;
        req_i = 8'b1000_0000;
        wait_grant(8'b1000_0000, "R1 ch7 alone");
        req_i[0] = 1'b1;
        cycles(6);
        chk(ack_o == 8'b1000_0000, "R2 ch7 kept despite ch0", ack_o, 8'h80);
        end_session(7, "R3 gap after ch7");
        wait_grant(8'b0000_0001, "R2 ch0 after session");
        end_session(0, "R3 gap after ch0");
    endtask

    task automatic t_mask;
        mask_i = 8'b0000_0001;
        req_i  = 8'b0000_1001;
        wait_grant(8'b0000_1000, "R6 masked ch0 skipped");
        end_session(3, "R3 gap after ch3 masked run");
        cycles(4);
        chk(ack_o == 0, "R6 masked ch0 never acked", ack_o, 0);
        chk(hold_req_o == 0, "R6 masked ch0 no hold", hold_req_o, 0);
        req_i = 8'b0;
        mask_i = 8'hFF;
        req_i = 8'b1110_1111;
        cycles(5);
        chk(hold_req_o == 0, "R6 all masked no hold", hold_req_o, 0);
        chk(ack_o == 0, "R6 all masked no ack", ack_o, 0);
        req_i = 8'b0;
        mask_i = 8'b0;
    endtask

    task automatic t_cascade_bit;
        mask_i = 8'b0000_0000;
        req_i  = 8'b0001_0000;
        cycles(6);
        chk(hold_req_o == 0, "R6 req bit4 no hold", hold_req_o, 0);
        chk(ack_o == 0, "R6 req bit4 no ack", ack_o, 0);
        req_i = 8'b0;
    endtask

    task automatic t_hlda;
        hlda_i = 1'b0;
        req_i  = 8'b0010_0000;
        cycles(2);
        chk(hold_req_o == 1, "R4 hold within two cycles", hold_req_o, 1);
        cycles(4);
        chk(ack_o == 0, "R5 no ack without hlda", ack_o, 0);
        hlda_i = 1'b1;
        wait_grant(8'b0010_0000, "R5 ack after hlda");
        chk(wide_o == 1, "R8 wide ch5", wide_o, 1);
        end_session(5, "R3 gap after ch5");
        chk(wide_o == 0, "R8 wide clears", wide_o, 0);
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_slave_order();
        t_cross_group();
        t_nonpreempt();
        t_mask();
        t_cascade_bit();
        t_hlda();
        chk(!multi_seen, "R7 single ack throughout", multi_seen, 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule